// File: doc/BRIEF.md
# Load/Store Pipeline Stage with Destination Forwarding

This block is the memory-access step of an in-order pipeline. It holds a small word-wide data store with one write port and one read port. Each cycle it receives the instruction leaving the execute step, that step's result, its register-update and branch flags, a read address and a write request (enable, address, data). It produces a registered result for write-back: a ready flag, a register-update flag and the value to write.

Alongside the result it publishes a forwarding bundle for the execute step. The bundle carries a valid flag, the destination register number and the value. It is valid only when the instruction really writes a register, so stores and redirecting branches publish nothing. A load returns the addressed word. A store commits its data at the clock edge. Any other instruction passes the execute result through.

Top module: `mem_stage`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first enabled cycle, `ready`, `update_rd`, `rd_value`, `fwd_valid`, `fwd_reg` and `fwd_value` are all zero. Every data word reads as zero after reset.
- R2: `ready` is high in the cycle after a clock edge with `enable` high, and low after an edge with `enable` low. After an edge with `enable` low, all other outputs keep their values and no word is written, even with `wr_en` high.
- R3: A load is an instruction with bits [27:26] equal to 01 and bit 20 set. An enabled load that is not redirecting sets `update_rd`, and `rd_value` equals the word at `rd_addr` after the next edge.
- R4: For such a load, `fwd_valid` is set, `fwd_reg` equals instruction bits [15:12], and `fwd_value` equals the loaded word.
- R5: A store is an instruction with bits [27:26] equal to 01 and bit 20 clear. On an enabled edge with `wr_en` high, the word at `wr_addr` takes `wr_data`. An enabled store leaves `update_rd` and `fwd_valid` low.
- R6: A committed word keeps its value after `wr_en` falls, whatever `wr_data` then carries.
- R7: A load in the cycle after a store to the same address returns the newly stored word.
- R8: When a write and a read target the same address in the same enabled cycle, the read returns the incoming write data.
- R9: For any other instruction (bits [27:26] not equal to 01), `update_rd` and `fwd_valid` equal the execute update flag. `rd_value` and `fwd_value` equal the execute result, and `fwd_reg` equals bits [15:12].
- R10: An enabled instruction with `ex_update_pc` set produces neither a register update nor a forward.
- R11: Bit 20 has no effect when bits [27:26] are not 01: such an instruction behaves as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Stage advances and may write when high |
| inst | input | INST_W | Instruction from the execute step |
| ex_result | input | DATA_W | Execute step result value |
| ex_update_rd | input | 1 | Execute step wants a register written |
| ex_update_pc | input | 1 | Execute step redirected the program counter |
| rd_addr | input | ADDR_W | Data store read address |
| wr_en | input | 1 | Data store write request |
| wr_addr | input | ADDR_W | Data store write address |
| wr_data | input | DATA_W | Data store write value |
| ready | output | 1 | Registered result is fresh |
| update_rd | output | 1 | Write-back should update a register |
| rd_value | output | DATA_W | Value for the destination register |
| fwd_valid | output | 1 | Forwarding bundle is valid |
| fwd_reg | output | REG_W | Destination register of the forwarded value |
| fwd_value | output | DATA_W | Forwarded value |

## Verification
The bench builds the block with its defaults: a 32-bit word, a 64-word store (6 address bits) and 4-bit register numbers. With only 64 words, random addresses often land on recently written locations. This reaches the store-then-load (R7) and same-cycle collision (R8) cases many times, not just in the directed steps. The full 32-bit width lets sentinel patterns expose dropped or swapped bits in both the loaded and the forwarded value.

// File: rtl/mem_stage_pkg.sv
package mem_stage_pkg;

    // Instruction field positions decoded by this stage
    localparam int XFER_HI  = 27;
    localparam int XFER_LO  = 26;
    localparam int LOAD_BIT = 20;
    localparam int DEST_HI  = 15;
    localparam int DEST_LO  = 12;

    localparam logic [1:0] XFER_CODE = 2'b01;

    typedef enum logic [1:0] {
        CLS_OTHER = 2'd0,
        CLS_LOAD  = 2'd1,
        CLS_STORE = 2'd2
    } op_class_e;

endpackage

// File: rtl/ms_classify.sv
module ms_classify
    import mem_stage_pkg::*;
#(
    parameter int INST_W = 32,
    parameter int REG_W  = 4
) (
    input  logic [INST_W-1:0] inst,
    output op_class_e         cls,
    output logic [REG_W-1:0]  dest
);
    logic unused_inst;
    assign unused_inst = ^inst;

    always_comb begin
        if (inst[XFER_HI:XFER_LO] == XFER_CODE) begin
            cls = inst[LOAD_BIT] ? CLS_LOAD : CLS_STORE;
        end else begin
            cls = CLS_OTHER;
        end
        dest = inst[DEST_LO +: REG_W];
    end
endmodule

// File: rtl/ms_word_ram.sv
module ms_word_ram #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              collide;

    always_comb begin
        collide = wr_en && (wr_addr == rd_addr);
        rd_data = collide ? wr_data : mem_q[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // R6: a write request leaves its data in the addressed word
    a_r6_write_commits: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/mem_stage.sv
module mem_stage
    import mem_stage_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64,
    parameter int INST_W = 32,
    parameter int REG_W  = 4,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [INST_W-1:0] inst,
    input  logic [DATA_W-1:0] ex_result,
    input  logic              ex_update_rd,
    input  logic              ex_update_pc,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ready,
    output logic              update_rd,
    output logic [DATA_W-1:0] rd_value,
    output logic              fwd_valid,
    output logic [REG_W-1:0]  fwd_reg,
    output logic [DATA_W-1:0] fwd_value
);
    typedef struct packed {
        logic              ready;
        logic              upd;
        logic [DATA_W-1:0] val;
        logic              fv;
        logic [REG_W-1:0]  freg;
        logic [DATA_W-1:0] fval;
    } stage_t;

    stage_t            st_d, st_q;
    op_class_e         cls;
    logic [REG_W-1:0]  dest;
    logic [DATA_W-1:0] mem_word;
    logic              ram_we;

    ms_classify #(.INST_W(INST_W), .REG_W(REG_W)) u_classify (
        .inst (inst),
        .cls  (cls),
        .dest (dest)
    );

    assign ram_we = enable && wr_en;

    ms_word_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ram_we),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (mem_word)
    );

    always_comb begin
        logic              wants;
        logic [DATA_W-1:0] value;
        st_d  = st_q;
        wants = 1'b0;
        value = ex_result;
        unique case (cls)
            CLS_LOAD: begin
                wants = 1'b1;
                value = mem_word;
            end
            CLS_STORE: wants = 1'b0;
            default:   wants = ex_update_rd;
        endcase
        if (ex_update_pc) begin
            wants = 1'b0;
        end
        st_d.ready = enable;
        if (enable) begin
            st_d.upd  = wants;
            st_d.val  = value;
            st_d.fv   = wants;
            st_d.freg = dest;
            st_d.fval = value;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready     = st_q.ready;
    assign update_rd = st_q.upd;
    assign rd_value  = st_q.val;
    assign fwd_valid = st_q.fv;
    assign fwd_reg   = st_q.freg;
    assign fwd_value = st_q.fval;

    a_r2_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> ready);
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!ready && $stable(rd_value) && $stable(fwd_valid)));
    a_r4_load_tagged: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && cls == CLS_LOAD && !ex_update_pc) |=>
            (fwd_valid && fwd_reg == $past(inst[DEST_LO +: REG_W]) && fwd_value == rd_value));
    a_r5_store_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && cls == CLS_STORE) |=> (!update_rd && !fwd_valid));
    a_r10_redirect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && ex_update_pc) |=> (!update_rd && !fwd_valid));
endmodule

// File: tb/mem_stage_tb.sv
module mem_stage_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 32;
    localparam int DEPTH  = 64;
    localparam int AW     = 6;
    localparam int RW     = 4;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          enable = 0;
    logic [31:0]   inst = 0;
    logic [31:0]   ex_result = 0;
    logic          ex_update_rd = 0;
    logic          ex_update_pc = 0;
    logic [AW-1:0] rd_addr = 0;
    logic          wr_en = 0;
    logic [AW-1:0] wr_addr = 0;
    logic [31:0]   wr_data = 0;
    logic          ready, update_rd, fwd_valid;
    logic [31:0]   rd_value, fwd_value;
    logic [RW-1:0] fwd_reg;

    mem_stage u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .inst(inst),
        .ex_result(ex_result), .ex_update_rd(ex_update_rd), .ex_update_pc(ex_update_pc),
        .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ready(ready), .update_rd(update_rd), .rd_value(rd_value),
        .fwd_valid(fwd_valid), .fwd_reg(fwd_reg), .fwd_value(fwd_value)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [31:0]   m_mem [DEPTH];
    logic          m_ready = 0, m_upd = 0, m_fv = 0;
    logic [31:0]   m_val = 0, m_fval = 0;
    logic [RW-1:0] m_freg = 0;
    string         m_tag = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            m_ready = 0; m_upd = 0; m_fv = 0; m_val = 0; m_fval = 0; m_freg = 0;
            m_tag = "R1";
        end else begin
            m_ready = enable;
            if (!enable) begin
                m_tag = "R2";
            end else begin
                bit is_xfer, is_ld, w;
                logic [31:0] v;
                is_xfer = (inst[27:26] == 2'b01);
                is_ld   = is_xfer && inst[20];
                v = ex_result;
                if (is_ld) begin
                    v = (wr_en && wr_addr == rd_addr) ? wr_data : m_mem[rd_addr];
                    w = 1; m_tag = "R3";
                end else if (is_xfer) begin
                    w = 0; m_tag = "R5";
                end else begin
                    w = ex_update_rd; m_tag = "R9";
                end
                if (ex_update_pc) begin
                    w = 0; m_tag = "R10";
                end
                if (wr_en) m_mem[wr_addr] = wr_data;
                m_upd = w; m_fv = w; m_val = v; m_fval = v; m_freg = inst[15:12];
            end
        end
    end

    bit model_on = 0;
    always @(negedge clk) begin
        if (model_on) begin
            check(ready == m_ready, "R2", "ready", ready, m_ready);
            check(update_rd == m_upd, m_tag, "update_rd", update_rd, m_upd);
            check(rd_value == m_val, m_tag, "rd_value", rd_value, m_val);
            check(fwd_valid == m_fv, (m_tag == "R3") ? "R4" : m_tag, "fwd_valid", fwd_valid, m_fv);
            check(fwd_reg == m_freg, (m_tag == "R3") ? "R4" : m_tag, "fwd_reg", fwd_reg, m_freg);
            check(fwd_value == m_fval, (m_tag == "R3") ? "R4" : m_tag, "fwd_value", fwd_value, m_fval);
        end
    end

    function automatic logic [31:0] op_load(input int rd);
        return 32'h0410_0000 | (rd << 12);
    endfunction
    function automatic logic [31:0] op_store(input int rd);
        return 32'h0400_0000 | (rd << 12);
    endfunction
    function automatic logic [31:0] op_other(input int rd);
        return 32'hE000_0000 | (rd << 12);
    endfunction

    task automatic cyc(input logic en, input logic [31:0] ins, input logic [31:0] res,
                       input logic eupd, input logic epc, input int ra,
                       input logic we, input int wa, input logic [31:0] wd);
        enable = en; inst = ins; ex_result = res; ex_update_rd = eupd;
        ex_update_pc = epc; rd_addr = AW'(ra); wr_en = we; wr_addr = AW'(wa); wr_data = wd;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!ready && !update_rd && !fwd_valid && rd_value == 0 && fwd_value == 0 && fwd_reg == 0,
              "R1", "outputs in reset", {ready, update_rd, fwd_valid}, 0);
        rst_n = 1;
        model_on = 1;
        @(negedge clk);

        // R5: store to word 5
        cyc(1, op_store(5), 32'h1111_1111, 0, 0, 0, 1, 5, 32'hDEAD_BEEF);
        // R7 / R4: load of word 5 on the next cycle into register 4
        cyc(1, op_load(4), 32'h0, 0, 0, 5, 0, 0, 32'hAABB_CCDD);
        check(rd_value == 32'hDEAD_BEEF, "R7", "load after store", rd_value, 32'hDEAD_BEEF);
        check(fwd_valid && fwd_reg == 4 && fwd_value == 32'hDEAD_BEEF, "R4", "forward tag",
              fwd_reg, 4);
        // R6: write enable dropped with junk data, word still committed
        cyc(1, op_other(2), 32'h5, 0, 0, 0, 0, 5, 32'h0BAD_0BAD);
        cyc(1, op_load(7), 32'h0, 0, 0, 5, 0, 5, 32'h0BAD_0BAD);
        check(rd_value == 32'hDEAD_BEEF, "R6", "word persists", rd_value, 32'hDEAD_BEEF);
        // R8: same-cycle write and read of word 9
        cyc(1, op_load(3), 32'h0, 0, 0, 9, 1, 9, 32'h1234_5678);
        check(rd_value == 32'h1234_5678, "R8", "collision bypass", rd_value, 32'h1234_5678);
        // R9: pass-through with and without update
        cyc(1, op_other(6), 32'hCAFE_F00D, 1, 0, 9, 0, 0, 0);
        check(update_rd && fwd_valid && rd_value == 32'hCAFE_F00D && fwd_reg == 6, "R9",
              "pass-through", rd_value, 32'hCAFE_F00D);
        cyc(1, op_other(6), 32'h7777_7777, 0, 0, 9, 0, 0, 0);
        check(!update_rd && !fwd_valid, "R9", "no update requested", update_rd, 0);
        // R10: redirect suppresses a load
        cyc(1, op_load(1), 32'h0, 1, 1, 5, 0, 0, 0);
        check(!update_rd && !fwd_valid, "R10", "redirect quiet", update_rd, 0);
        // R11: bit 20 set with bits [27:26] = 11 acts as pass-through
        cyc(1, 32'h0C10_0000 | (8 << 12), 32'h4242_4242, 1, 0, 5, 0, 0, 0);
        check(update_rd && rd_value == 32'h4242_4242, "R11", "not a load", rd_value, 32'h4242_4242);
        // R2: disabled cycle with write request must not write
        cyc(0, op_store(0), 32'h0, 0, 0, 0, 1, 5, 32'hFFFF_0000);
        check(!ready && rd_value == 32'h4242_4242, "R2", "idle hold", rd_value, 32'h4242_4242);
        cyc(1, op_load(2), 32'h0, 0, 0, 5, 0, 0, 0);
        check(rd_value == 32'hDEAD_BEEF, "R2", "idle wrote nothing", rd_value, 32'hDEAD_BEEF);

        // Mixed traffic compared against the model every cycle
        for (int k = 0; k < 400; k++) begin
            int sel;
            logic [31:0] ins;
            sel = $urandom_range(0, 3);
            ins = (sel == 0) ? op_load($urandom_range(0, 15)) :
                  (sel == 1) ? op_store($urandom_range(0, 15)) :
                  (sel == 2) ? op_other($urandom_range(0, 15)) : $urandom;
            cyc(($urandom_range(0, 7) != 0), ins, $urandom, $urandom_range(0, 1),
                ($urandom_range(0, 9) == 0), $urandom_range(0, 15), $urandom_range(0, 1),
                $urandom_range(0, 15), $urandom);
        end

        model_on = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule